// File: doc/BRIEF.md
# Multiprocessor-Capable Asynchronous Serial Port

This block is a full-duplex asynchronous serial channel. The transmitter and the receiver run independently of each other. Both take their timing from a shared sample tick, which comes from a programmable divider of the system clock. The receiver samples the line at `OVS` ticks per bit, and it qualifies the start bit at its mid-point. The transmitter sends one start bit, `DATA_W` data bits with the least significant bit first, and one stop bit. In multiprocessor format it inserts an extra address/data marker bit between the last data bit and the stop bit.

Software reaches the block through a small register port with four locations:

| Address | Register |
|---|---|
| 0 | Data (write = transmit holding byte, read = received byte) |
| 1 | Control |
| 2 | Status |
| 3 | Baud divisor |

Each channel has one holding register and no deeper buffering.

In multiprocessor format the receiver can filter out any frame whose marker bit is 0. Such a frame is dropped silently, so a listening node only wakes for address frames. The receiver recognises an all-zero frame as a line break. The transmitter holds the line low for as long as software keeps the break control bit set. RTS is driven from a control bit. CTS gates the start of every transmit frame. DCD gates the start of every receive frame.

Top module: `mpser_port`

## Requirements
- R1: After reset, `txd_o` is 1, `rts_o` is 0, `rx_ready_o` is 0, and the status register (address 2) reads with bit 1 (transmit holding empty) set and bits 0, 2, 3 and 4 clear.
- R2: A byte written to address 0 is sent as a 0 start bit, then the data bits with the least significant bit first, then a 1 stop bit. Each bit lasts `OVS*(divisor+1)` clock cycles, where the divisor is the value in address 3.
- R3: When control bit 0 (multiprocessor format) is set, the transmitter places one extra bit between the data and the stop bit. That bit equals control bit 4.
- R4: While `cts_i` is 0, no transmit frame starts, `txd_o` stays 1, and status bit 1 reads 0 while a byte waits. The waiting byte is sent once `cts_i` returns to 1.
- R5: While control bit 2 (send break) is set, `txd_o` is held at 0. When the bit is cleared, the line returns to 1.
- R6: A received frame with a 1 stop bit loads the data into address 0 and sets `rx_ready_o` and status bit 0. A read of address 0 clears both.
- R7: A low pulse on `rxd_i` that is shorter than half a bit time is not taken as a start bit, and no data is received.
- R8: When control bits 0 and 1 (multiprocessor filter) are both set, a frame whose marker bit is 0 is discarded and `rx_ready_o` stays 0. A frame whose marker bit is 1 is accepted, and the marker bit is reported in status bit 2.
- R9: A frame whose data bits, marker bit and stop bit are all 0 sets status bit 3 (break) and does not set `rx_ready_o`. A read of the status register clears bit 3.
- R10: A frame with a nonzero data field and a 0 stop bit is still loaded and sets `rx_ready_o`. It also sets status bit 4 (framing error), which a status read clears.
- R11: `rts_o` follows control bit 3. Status bits 5 and 6 show `cts_i` and `dcd_i`.
- R12: While `dcd_i` is 0, the receiver starts no frame, and `rx_ready_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (read side effects) |
| host_addr | input | 2 | Register select |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data for the selected register |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line |
| rts_o | output | 1 | Request-to-send, from control bit 3 |
| cts_i | input | 1 | Clear-to-send, 1 allows a transmit frame to start |
| dcd_i | input | 1 | Carrier detect, 1 allows a receive frame to start |
| rx_ready_o | output | 1 | A received byte is waiting |

## Verification
The assertions take three things for granted:

- The control register does not change in the same cycle in which a received frame completes.
- `cts_i` and `dcd_i` are synchronous to `clk`.
- The divisor is not rewritten while a frame is in flight.

The stimulus respects all three. Every control write, divisor write and modem-line change is made only while both serial lines are idle. All inputs are driven away from the active clock edge. Serial frames arrive on `rxd_i` with whole bit times that match the programmed divisor.

// File: rtl/mpser_pkg.sv
package mpser_pkg;

   typedef enum logic [1:0] {
      REG_DATA = 2'd0,
      REG_CTRL = 2'd1,
      REG_STAT = 2'd2,
      REG_BAUD = 2'd3
   } reg_sel_e;

   // control register bit positions
   localparam int unsigned CB_MP    = 0;
   localparam int unsigned CB_FILT  = 1;
   localparam int unsigned CB_BRK   = 2;
   localparam int unsigned CB_RTS   = 3;
   localparam int unsigned CB_MPTX  = 4;
   localparam int unsigned CTRL_W   = 5;

   // status register bit positions
   localparam int unsigned SB_RDY   = 0;
   localparam int unsigned SB_TXE   = 1;
   localparam int unsigned SB_MPB   = 2;
   localparam int unsigned SB_BRK   = 3;
   localparam int unsigned SB_FERR  = 4;
   localparam int unsigned SB_CTS   = 5;
   localparam int unsigned SB_DCD   = 6;
   localparam int unsigned STAT_W   = 7;

   typedef enum logic [1:0] {
      RXE_NONE  = 2'd0,
      RXE_LOAD  = 2'd1,
      RXE_BREAK = 2'd2,
      RXE_DROP  = 2'd3
   } rx_evt_e;

endpackage

// File: rtl/mpser_baud.sv
module mpser_baud #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);

   logic [DIV_W-1:0] cnt_q;

   assign tick_o = (cnt_q >= div_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (tick_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R2: ticks are spaced by divisor+1 clocks, so a nonzero divisor never gives two in a row
   p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && div_i != '0) |=> (!tick_o || div_i == '0));

endmodule

// File: rtl/mpser_tx.sv
module mpser_tx #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              mp_mode_i,
   input  logic              mp_bit_i,
   input  logic              brk_i,
   input  logic              cts_i,
   input  logic              hold_full_i,
   input  logic [DATA_W-1:0] hold_data_i,
   output logic              take_o,
   output logic              busy_o,
   output logic              txd_o
);

   localparam int unsigned FW = DATA_W + 3;
   localparam int unsigned CW = $clog2(OVS);
   localparam int unsigned BW = $clog2(FW) + 1;
   localparam logic [CW-1:0] CNT_END = CW'(OVS - 1);
   localparam logic [BW-1:0] LAST_MP = BW'(FW - 1);
   localparam logic [BW-1:0] LAST_PL = BW'(FW - 2);

   logic [FW-1:0] sh_q;
   logic [CW-1:0] cnt_q;
   logic [BW-1:0] bidx_q;
   logic [BW-1:0] last_q;
   logic          busy_q;
   logic [FW-1:0] frame_w;
   logic          start_w;

   assign frame_w = {1'b1, (mp_mode_i ? mp_bit_i : 1'b1), hold_data_i, 1'b0};
   assign start_w = !busy_q && hold_full_i && cts_i && !brk_i;
   assign take_o  = start_w;
   assign busy_o  = busy_q;
   assign txd_o   = brk_i ? 1'b0 : (busy_q ? sh_q[0] : 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '1;
         cnt_q  <= '0;
         bidx_q <= '0;
         last_q <= LAST_PL;
         busy_q <= 1'b0;
      end else if (start_w) begin
         sh_q   <= frame_w;
         cnt_q  <= '0;
         bidx_q <= '0;
         last_q <= mp_mode_i ? LAST_MP : LAST_PL;
         busy_q <= 1'b1;
      end else if (busy_q && tick_i) begin
         if (cnt_q == CNT_END) begin
            cnt_q <= '0;
            if (bidx_q == last_q) begin
               busy_q <= 1'b0;
               sh_q   <= '1;
            end else begin
               bidx_q <= bidx_q + 1'b1;
               sh_q   <= {1'b1, sh_q[FW-1:1]};
            end
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R4: a frame may only begin in a cycle where CTS allowed it and no break was requested
   p_cts_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> ($past(cts_i) && !$past(brk_i)));

   // R2: the first bit on the line after a frame begins is the low start bit
   p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> (txd_o == 1'b0));

endmodule

// File: rtl/mpser_rx.sv
module mpser_rx
   import mpser_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned OVS         = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              rxd_i,
   input  logic              dcd_i,
   input  logic              mp_mode_i,
   input  logic              mp_filt_i,
   output rx_evt_e           evt_o,
   output logic [DATA_W-1:0] data_o,
   output logic              mpb_o,
   output logic              stop_o
);

   localparam int unsigned SW = DATA_W + 2;
   localparam int unsigned CW = $clog2(OVS);
   localparam int unsigned BW = $clog2(SW) + 1;
   localparam logic [CW-1:0] CNT_END  = CW'(OVS - 1);
   localparam logic [CW-1:0] HALF_END = CW'(OVS / 2 - 1);
   localparam logic [BW-1:0] LAST_MP  = BW'(DATA_W + 1);
   localparam logic [BW-1:0] LAST_PL  = BW'(DATA_W);

   typedef enum logic [1:0] {S_IDLE, S_START, S_BITS} rx_st_e;

   logic          rxs;
   rx_st_e        st_q;
   logic [CW-1:0] cnt_q;
   logic [BW-1:0] bidx_q;
   logic [SW-1:0] sh_q;
   logic [SW-1:0] sh_nx;
   logic          armed_q;
   logic [BW-1:0] last_w;

   // line synchroniser: depth chosen by parameter
   if (SYNC_STAGES == 0) begin : g_nosync
      assign rxs = rxd_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] ff_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ff_q <= '1;
         else        ff_q <= (ff_q << 1) | SYNC_STAGES'(rxd_i);
      end
      assign rxs = ff_q[SYNC_STAGES-1];
   end

   assign last_w = mp_mode_i ? LAST_MP : LAST_PL;

   always_comb begin
      sh_nx         = sh_q;
      sh_nx[bidx_q] = rxs;
   end

   // classification of a finished frame
   logic [DATA_W-1:0] f_data;
   logic              f_mpb;
   logic              f_stop;
   rx_evt_e           f_evt;

   always_comb begin
      f_data = sh_nx[DATA_W-1:0];
      f_mpb  = mp_mode_i ? sh_nx[DATA_W] : 1'b0;
      f_stop = mp_mode_i ? sh_nx[DATA_W+1] : sh_nx[DATA_W];
      if (f_data == '0 && !f_mpb && !f_stop)       f_evt = RXE_BREAK;
      else if (mp_mode_i && mp_filt_i && !f_mpb)   f_evt = RXE_DROP;
      else                                         f_evt = RXE_LOAD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         cnt_q   <= '0;
         bidx_q  <= '0;
         sh_q    <= '0;
         armed_q <= 1'b0;
         evt_o   <= RXE_NONE;
         data_o  <= '0;
         mpb_o   <= 1'b0;
         stop_o  <= 1'b1;
      end else begin
         evt_o <= RXE_NONE;
         if (tick_i) begin
            unique case (st_q)
               S_IDLE: begin
                  if (rxs) begin
                     armed_q <= 1'b1;
                  end else if (armed_q && dcd_i) begin
                     st_q  <= S_START;
                     cnt_q <= '0;
                  end
               end
               S_START: begin
                  if (cnt_q == HALF_END) begin
                     cnt_q <= '0;
                     if (!rxs) begin
                        st_q   <= S_BITS;
                        bidx_q <= '0;
                        sh_q   <= '0;
                     end else begin
                        st_q <= S_IDLE;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               S_BITS: begin
                  if (cnt_q == CNT_END) begin
                     cnt_q <= '0;
                     sh_q  <= sh_nx;
                     if (bidx_q == last_w) begin
                        st_q    <= S_IDLE;
                        armed_q <= 1'b0;
                        evt_o   <= f_evt;
                        data_o  <= f_data;
                        mpb_o   <= f_mpb;
                        stop_o  <= f_stop;
                     end else begin
                        bidx_q <= bidx_q + 1'b1;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: st_q <= S_IDLE;
            endcase
         end
      end
   end

   // R6: a frame result only appears right after the bit-collection phase
   p_evt_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_o != RXE_NONE) |-> ($past(st_q) == S_BITS));

   // R12: a frame can only leave idle while carrier detect is asserted
   p_dcd_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_START && $past(st_q) == S_IDLE) |-> $past(dcd_i));

endmodule

// File: rtl/mpser_port.sv
module mpser_port
   import mpser_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned DIV_W       = 8,
   parameter int unsigned OVS         = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [1:0]        host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              txd_o,
   input  logic              rxd_i,
   output logic              rts_o,
   input  logic              cts_i,
   input  logic              dcd_i,
   output logic              rx_ready_o
);

   initial begin
      if (DATA_W < STAT_W + 1) $error("mpser_port: DATA_W must hold the status field");
      if (DIV_W > DATA_W)      $error("mpser_port: DIV_W must not exceed DATA_W");
      if (OVS < 4 || (OVS % 2) != 0) $error("mpser_port: OVS must be even and at least 4");
   end

   logic [CTRL_W-1:0] ctrl_q;
   logic [DIV_W-1:0]  div_q;
   logic [DATA_W-1:0] hold_q;
   logic              hold_full_q;
   logic [DATA_W-1:0] rxbuf_q;
   logic              rdy_q;
   logic              mpb_q;
   logic              brk_q;
   logic              ferr_q;

   logic              tick;
   logic              take;
   logic              tx_busy;
   rx_evt_e           rx_evt;
   logic [DATA_W-1:0] rx_data;
   logic              rx_mpb;
   logic              rx_stop;

   reg_sel_e sel;
   assign sel = reg_sel_e'(host_addr);

   logic wr_data, wr_ctrl, wr_baud, rd_data, rd_stat;
   assign wr_data = host_wr && sel == REG_DATA;
   assign wr_ctrl = host_wr && sel == REG_CTRL;
   assign wr_baud = host_wr && sel == REG_BAUD;
   assign rd_data = host_rd && sel == REG_DATA;
   assign rd_stat = host_rd && sel == REG_STAT;

   mpser_baud #(.DIV_W(DIV_W)) i_baud (
      .clk    (clk),
      .rst_n  (rst_n),
      .div_i  (div_q),
      .tick_o (tick)
   );

   mpser_tx #(.DATA_W(DATA_W), .OVS(OVS)) i_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick),
      .mp_mode_i   (ctrl_q[CB_MP]),
      .mp_bit_i    (ctrl_q[CB_MPTX]),
      .brk_i       (ctrl_q[CB_BRK]),
      .cts_i       (cts_i),
      .hold_full_i (hold_full_q),
      .hold_data_i (hold_q),
      .take_o      (take),
      .busy_o      (tx_busy),
      .txd_o       (txd_o)
   );

   mpser_rx #(.DATA_W(DATA_W), .OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) i_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .rxd_i     (rxd_i),
      .dcd_i     (dcd_i),
      .mp_mode_i (ctrl_q[CB_MP]),
      .mp_filt_i (ctrl_q[CB_FILT]),
      .evt_o     (rx_evt),
      .data_o    (rx_data),
      .mpb_o     (rx_mpb),
      .stop_o    (rx_stop)
   );

   // host-side registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q      <= '0;
         div_q       <= '0;
         hold_q      <= '0;
         hold_full_q <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= host_wdata[CTRL_W-1:0];
         if (wr_baud) div_q  <= host_wdata[DIV_W-1:0];
         if (wr_data) begin
            hold_q      <= host_wdata;
            hold_full_q <= 1'b1;
         end else if (take) begin
            hold_full_q <= 1'b0;
         end
      end
   end

   // receive-side holding register and flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxbuf_q <= '0;
         rdy_q   <= 1'b0;
         mpb_q   <= 1'b0;
         brk_q   <= 1'b0;
         ferr_q  <= 1'b0;
      end else begin
         if (rx_evt == RXE_LOAD) begin
            rxbuf_q <= rx_data;
            rdy_q   <= 1'b1;
            mpb_q   <= rx_mpb;
         end else if (rd_data) begin
            rdy_q <= 1'b0;
         end
         if (rx_evt == RXE_BREAK)                brk_q <= 1'b1;
         else if (rd_stat)                       brk_q <= 1'b0;
         if (rx_evt == RXE_LOAD && !rx_stop)     ferr_q <= 1'b1;
         else if (rd_stat)                       ferr_q <= 1'b0;
      end
   end

   logic [DATA_W-1:0] stat_w;
   always_comb begin
      stat_w          = '0;
      stat_w[SB_RDY]  = rdy_q;
      stat_w[SB_TXE]  = !hold_full_q;
      stat_w[SB_MPB]  = mpb_q;
      stat_w[SB_BRK]  = brk_q;
      stat_w[SB_FERR] = ferr_q;
      stat_w[SB_CTS]  = cts_i;
      stat_w[SB_DCD]  = dcd_i;
   end

   always_comb begin
      unique case (sel)
         REG_DATA: host_rdata = rxbuf_q;
         REG_CTRL: host_rdata = DATA_W'(ctrl_q);
         REG_STAT: host_rdata = stat_w;
         REG_BAUD: host_rdata = DATA_W'(div_q);
         default:  host_rdata = '0;
      endcase
   end

   assign rts_o      = ctrl_q[CB_RTS];
   assign rx_ready_o = rdy_q;

   // R6: a data read with no frame landing in the same cycle leaves receive-ready clear
   p_ready_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && rx_evt != RXE_LOAD) |=> !rx_ready_o);

   // R8: with the filter active, only a marker-bit-1 frame may raise receive-ready
   p_filter_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy_q) |-> (!($past(ctrl_q[CB_MP]) && $past(ctrl_q[CB_FILT])) || mpb_q));

   // R9: a break never raises receive-ready in the same cycle
   p_break_no_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brk_q) |-> !$rose(rdy_q));

   // R4: the holding register drains only while CTS is asserted
   p_hold_cts_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_full_q) |-> $past(cts_i));

endmodule

// File: tb/test_mpser_port.sv
module test_mpser_port;

   localparam int DATA_W   = 8;
   localparam int OVS      = 16;
   localparam int DIV      = 1;
   localparam int BIT      = OVS * (DIV + 1);
   localparam int HALF_BIT = BIT / 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              host_wr = 1'b0;
   logic              host_rd = 1'b0;
   logic [1:0]        host_addr = 2'd0;
   logic [DATA_W-1:0] host_wdata = '0;
   logic [DATA_W-1:0] host_rdata;
   logic              txd_o;
   logic              rxd_i = 1'b1;
   logic              rts_o;
   logic              cts_i = 1'b1;
   logic              dcd_i = 1'b1;
   logic              rx_ready_o;

   int n_chk  = 0;
   int n_fail = 0;

   // reference-model state, updated from the stimulus side
   bit m_brk   = 1'b0;
   bit m_quiet = 1'b0;
   bit m_no_rx = 1'b0;

   always #10 clk = ~clk;

   mpser_port #(.DATA_W(DATA_W), .DIV_W(8), .OVS(OVS), .SYNC_STAGES(2)) i_mpser_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr    (host_wr),
      .host_rd    (host_rd),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .txd_o      (txd_o),
      .rxd_i      (rxd_i),
      .rts_o      (rts_o),
      .cts_i      (cts_i),
      .dcd_i      (dcd_i),
      .rx_ready_o (rx_ready_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         if (m_brk)   chk(txd_o == 1'b0, "R5 line held low", int'(txd_o), 0);
         if (m_quiet) chk(txd_o == 1'b1, "R4 line idle without CTS", int'(txd_o), 1);
         if (m_no_rx) chk(rx_ready_o == 1'b0, "R7/R8/R12 no receive", int'(rx_ready_o), 0);
      end
   end

   task automatic host_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic host_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_rd = 1'b1;
      #1 d = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   // sample a transmitted frame at bit mid-points; returns bits after the start bit
   task automatic cap_frame(input int nb, output logic [15:0] bits);
      int w = 0;
      bits = '0;
      while (txd_o !== 1'b0 && w < 6000) begin
         @(negedge clk); w++;
      end
      chk(w < 6000, "R2 frame start seen", w, 0);
      repeat (HALF_BIT) @(negedge clk);
      chk(txd_o == 1'b0, "R2 start bit", int'(txd_o), 0);
      for (int i = 0; i < nb; i++) begin
         repeat (BIT) @(negedge clk);
         bits[i] = txd_o;
      end
   endtask

   task automatic send_frame(input logic [7:0] d, input bit mp, input bit mpb, input bit stp);
      @(negedge clk);
      rxd_i = 1'b0;
      repeat (BIT) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rxd_i = d[i];
         repeat (BIT) @(negedge clk);
      end
      if (mp) begin
         rxd_i = mpb;
         repeat (BIT) @(negedge clk);
      end
      rxd_i = stp;
      repeat (BIT) @(negedge clk);
      rxd_i = 1'b1;
      repeat (2 * BIT) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0]  rd;
      logic [15:0] b;

      repeat (3) @(negedge clk);
      // R1: reset state
      chk(txd_o == 1'b1, "R1 txd idle", int'(txd_o), 1);
      chk(rts_o == 1'b0, "R1 rts low", int'(rts_o), 0);
      chk(rx_ready_o == 1'b0, "R1 rx_ready low", int'(rx_ready_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      host_read(2'd2, rd);
      chk(rd == 8'h62, "R1 status after reset", rd, 8'h62);

      host_write(2'd3, 8'(DIV));
      // R11: RTS follows control bit 3, modem inputs visible
      host_write(2'd1, 8'h08);
      chk(rts_o == 1'b1, "R11 rts set", int'(rts_o), 1);
      cts_i = 1'b0; dcd_i = 1'b0;
      host_read(2'd2, rd);
      chk(rd[6:5] == 2'b00, "R11 cts/dcd low in status", rd[6:5], 0);
      cts_i = 1'b1; dcd_i = 1'b1;
      host_read(2'd2, rd);
      chk(rd[6:5] == 2'b11, "R11 cts/dcd high in status", rd[6:5], 3);

      // R2: plain frame
      host_write(2'd0, 8'hA5);
      cap_frame(9, b);
      chk(b[7:0] == 8'hA5, "R2 data bits", b[7:0], 8'hA5);
      chk(b[8] == 1'b1, "R2 stop bit", b[8], 1);
      repeat (BIT) @(negedge clk);
      chk(txd_o == 1'b1, "R2 idle after frame", int'(txd_o), 1);

      // R3: multiprocessor marker bit 1 then 0
      host_write(2'd1, 8'h19);
      host_write(2'd0, 8'h3C);
      cap_frame(10, b);
      chk(b[7:0] == 8'h3C, "R3 data bits", b[7:0], 8'h3C);
      chk(b[8] == 1'b1, "R3 marker bit one", b[8], 1);
      chk(b[9] == 1'b1, "R3 stop bit", b[9], 1);
      repeat (BIT) @(negedge clk);
      host_write(2'd1, 8'h09);
      host_write(2'd0, 8'h81);
      cap_frame(10, b);
      chk(b[7:0] == 8'h81, "R3 data bits", b[7:0], 8'h81);
      chk(b[8] == 1'b0, "R3 marker bit zero", b[8], 0);
      chk(b[9] == 1'b1, "R3 stop bit", b[9], 1);
      repeat (BIT) @(negedge clk);

      // R4: CTS gating
      host_write(2'd1, 8'h08);
      cts_i = 1'b0;
      m_quiet = 1'b1;
      host_write(2'd0, 8'h55);
      repeat (5 * BIT) @(negedge clk);
      host_read(2'd2, rd);
      chk(rd[1] == 1'b0, "R4 byte still waiting", rd[1], 0);
      m_quiet = 1'b0;
      cts_i = 1'b1;
      cap_frame(9, b);
      chk(b[7:0] == 8'h55, "R4 data after CTS", b[7:0], 8'h55);
      repeat (BIT) @(negedge clk);
      host_read(2'd2, rd);
      chk(rd[1] == 1'b1, "R4 holding empty after send", rd[1], 1);

      // R5: send break
      host_write(2'd1, 8'h0C);
      @(negedge clk);
      m_brk = 1'b1;
      repeat (3 * BIT) @(negedge clk);
      chk(txd_o == 1'b0, "R5 break level", int'(txd_o), 0);
      m_brk = 1'b0;
      host_write(2'd1, 8'h08);
      @(negedge clk);
      chk(txd_o == 1'b1, "R5 line released", int'(txd_o), 1);

      // R6: receive a byte
      send_frame(8'h4E, 1'b0, 1'b0, 1'b1);
      chk(rx_ready_o == 1'b1, "R6 ready set", int'(rx_ready_o), 1);
      host_read(2'd2, rd);
      chk(rd[0] == 1'b1, "R6 status ready", rd[0], 1);
      host_read(2'd0, rd);
      chk(rd == 8'h4E, "R6 received data", rd, 8'h4E);
      chk(rx_ready_o == 1'b0, "R6 ready cleared by read", int'(rx_ready_o), 0);

      // R7: short glitch
      m_no_rx = 1'b1;
      @(negedge clk);
      rxd_i = 1'b0;
      repeat (4) @(negedge clk);
      rxd_i = 1'b1;
      repeat (12 * BIT) @(negedge clk);
      chk(rx_ready_o == 1'b0, "R7 glitch rejected", int'(rx_ready_o), 0);
      m_no_rx = 1'b0;

      // R8: multiprocessor filter
      host_write(2'd1, 8'h0B);
      m_no_rx = 1'b1;
      send_frame(8'h11, 1'b1, 1'b0, 1'b1);
      chk(rx_ready_o == 1'b0, "R8 data frame dropped", int'(rx_ready_o), 0);
      m_no_rx = 1'b0;
      send_frame(8'h22, 1'b1, 1'b1, 1'b1);
      chk(rx_ready_o == 1'b1, "R8 address frame kept", int'(rx_ready_o), 1);
      host_read(2'd2, rd);
      chk(rd[2] == 1'b1, "R8 marker in status", rd[2], 1);
      host_read(2'd0, rd);
      chk(rd == 8'h22, "R8 address byte", rd, 8'h22);
      host_write(2'd1, 8'h08);

      // R9: break detection
      @(negedge clk);
      rxd_i = 1'b0;
      repeat (12 * BIT) @(negedge clk);
      rxd_i = 1'b1;
      repeat (2 * BIT) @(negedge clk);
      chk(rx_ready_o == 1'b0, "R9 break not ready", int'(rx_ready_o), 0);
      host_read(2'd2, rd);
      chk(rd[3] == 1'b1, "R9 break flag set", rd[3], 1);
      host_read(2'd2, rd);
      chk(rd[3] == 1'b0, "R9 break flag cleared by read", rd[3], 0);

      // R10: framing error
      send_frame(8'h5A, 1'b0, 1'b0, 1'b0);
      chk(rx_ready_o == 1'b1, "R10 ready with bad stop", int'(rx_ready_o), 1);
      host_read(2'd2, rd);
      chk(rd[4] == 1'b1, "R10 framing flag", rd[4], 1);
      chk(rd[3] == 1'b0, "R10 not a break", rd[3], 0);
      host_read(2'd0, rd);
      chk(rd == 8'h5A, "R10 data kept", rd, 8'h5A);
      host_read(2'd2, rd);
      chk(rd[4] == 1'b0, "R10 framing flag cleared", rd[4], 0);

      // R12: carrier detect gating
      dcd_i = 1'b0;
      m_no_rx = 1'b1;
      send_frame(8'h77, 1'b0, 1'b0, 1'b1);
      chk(rx_ready_o == 1'b0, "R12 no receive without DCD", int'(rx_ready_o), 0);
      m_no_rx = 1'b0;
      dcd_i = 1'b1;
      send_frame(8'h96, 1'b0, 1'b0, 1'b1);
      host_read(2'd0, rd);
      chk(rd == 8'h96, "R12 receive after DCD", rd, 8'h96);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule